// File: doc/BRIEF.md
# IDCT Coefficient Prescaler

This block conditions a block of 8x8 dequantised DCT coefficients ahead of a row-column inverse transform. Each incoming coefficient carries its row and column position. The block multiplies it by a fixed-point weight taken from a main table. It then adds a small signed correction: the coefficient times a residual table entry, arithmetically shifted right by the residual precision. The residual recovers the fraction that the main table loses at its limited width. Only at position (0,0) does the block also add half of the final scaling step, so the later downshift of every output pixel rounds to nearest.

Both tables come from the per-index separable weights a(k) and are computed at elaboration from the two precision parameters. A new coefficient can enter on every cycle. The result appears one cycle later, in the same order, with its position index carried alongside.

Top module: `coef_prescale`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is low.
- R2: out_valid equals in_valid delayed by exactly one clock cycle; back-to-back inputs produce back-to-back outputs.
- R3: out_row and out_col equal the in_row and in_col of the accepted input one cycle earlier.
- R4: The main weight at row i, column j is floor(a(i)*a(j)*2^P1 + 0.5). The factors are a(0)=a(4)=0.3535533906, a(1)=0.4499881115, a(2)=0.6532814824, a(3)=0.2548977895, a(5)=1.2814577239, a(6)=0.2705980501, a(7)=0.3006724435.
- R5: The residual weight is floor((a(i)*a(j)*2^P1 - main)*2^P2 + 0.5). It is a signed value and may be negative.
- R6: out_coef = x*main + ((x*residual) >>> P2). The shift is an arithmetic floor shift on the full-width product, so negative partial products round toward minus infinity.
- R7: 2^(P1-1) is added to the result when in_row = 0 and in_col = 0, and at no other position; a zero input elsewhere gives zero.
- R8: With the defaults P1 = 18 and P2 = 3, the main weight at (0,0) is 32768, so an input of 1 at DC gives 163840.
- R9: With P1 = 11, P2 = 5 and OUT_W = 24, the main weight at (0,0) is 256 and the bias is 1024.
- R10: Inputs across the full 11-bit magnitude range (-2047 to 2047) give exact results at every position, with no wrap in OUT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input coefficient present |
| in_row | input | 3 | Row position of the input |
| in_col | input | 3 | Column position of the input |
| in_coef | input | IN_W | Signed dequantised coefficient |
| out_valid | output | 1 | Output coefficient present |
| out_row | output | 3 | Forwarded row position |
| out_col | output | 3 | Forwarded column position |
| out_coef | output | OUT_W | Signed prescaled coefficient |

## Verification
The bench builds two instances that share one stimulus stream. The first uses the default 32-bit setting (P1 = 18, P2 = 3). The second uses the 24-bit setting (P1 = 11, P2 = 5, OUT_W = 24). Because the second setting has larger residual weights, its negative values and the floor behaviour of the compensation shift show up in many more of its outputs. It also puts the 11-bit input extremes near the top of a narrower output word. Running every one of the 64 positions through both instances exercises every table entry and shows that the DC bias lands at the origin only.

// File: rtl/coef_prescale.sv
module coef_prescale #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 32,
  parameter int P1    = 18,
  parameter int P2    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [2:0]              in_row,
  input  logic [2:0]              in_col,
  input  logic signed [IN_W-1:0]  in_coef,
  output logic                    out_valid,
  output logic [2:0]              out_row,
  output logic [2:0]              out_col,
  output logic signed [OUT_W-1:0] out_coef
);
  localparam int PW = OUT_W + P2;
  localparam int TW = 32;
  localparam logic signed [OUT_W-1:0] BIAS = OUT_W'(64'd1 << (P1 - 1));

  function automatic real axis_w(int k);
    case (k)
      0, 4:    return 0.3535533906;
      1:       return 0.4499881115;
      2:       return 0.6532814824;
      3:       return 0.2548977895;
      5:       return 1.2814577239;
      6:       return 0.2705980501;
      default: return 0.3006724435;
    endcase
  endfunction

  function automatic int main_w(int i, int j);
    real s;
    s = axis_w(i) * axis_w(j) * real'(longint'(1) << P1);
    return $rtoi(s + 0.5);
  endfunction

  function automatic int resid_w(int i, int j);
    real s, r;
    int t;
    s = axis_w(i) * axis_w(j) * real'(longint'(1) << P1);
    r = (s - real'(main_w(i, j))) * real'(longint'(1) << P2) + 0.5;
    t = $rtoi(r);
    if (real'(t) > r) t = t - 1;
    return t;
  endfunction

  logic signed [TW-1:0] main_tab  [64];
  logic signed [TW-1:0] resid_tab [64];

  for (genvar k = 0; k < 64; k++) begin : g_tab
    localparam int MW = main_w(k / 8, k % 8);
    localparam int RW = resid_w(k / 8, k % 8);
    assign main_tab[k]  = TW'(MW);
    assign resid_tab[k] = TW'(RW);
  end

  logic [5:0]              idx;
  logic signed [OUT_W-1:0] main_p, resid_sh, dc_add, total;
  logic signed [PW-1:0]    resid_p;

  assign idx      = {in_row, in_col};
  assign main_p   = OUT_W'(in_coef) * OUT_W'(main_tab[idx]);
  assign resid_p  = PW'(in_coef) * PW'(resid_tab[idx]);
  assign resid_sh = OUT_W'(resid_p >>> P2);
  assign dc_add   = (idx == 6'd0) ? BIAS : '0;
  assign total    = main_p + resid_sh + dc_add;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_row   <= '0;
      out_col   <= '0;
      out_coef  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_row  <= in_row;
        out_col  <= in_col;
        out_coef <= total;
      end
    end
  end
endmodule

// File: rtl/coef_prescale_chk.sv
module coef_prescale_chk #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 32,
  parameter int P1    = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [2:0]              in_row,
  input logic [2:0]              in_col,
  input logic signed [IN_W-1:0]  in_coef,
  input logic                    out_valid,
  input logic [2:0]              out_row,
  input logic [2:0]              out_col,
  input logic signed [OUT_W-1:0] out_coef
);
  localparam logic signed [OUT_W-1:0] BIAS = OUT_W'(64'd1 << (P1 - 1));

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_index_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_row == $past(in_row)) && (out_col == $past(in_col)));

  assert_zero_offdc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_coef == '0 && {in_row, in_col} != 6'd0 |=> out_coef == '0);

  assert_zero_dc_bias_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_coef == '0 && {in_row, in_col} == 6'd0 |=> out_coef == BIAS);
endmodule

bind coef_prescale coef_prescale_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .P1(P1)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row(in_row), .in_col(in_col),
  .in_coef(in_coef), .out_valid(out_valid), .out_row(out_row), .out_col(out_col),
  .out_coef(out_coef)
);

// File: tb/coef_prescale_tb.sv
`timescale 1ns/1ps
module coef_prescale_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_row = '0, in_col = '0;
  logic signed [11:0] in_coef = '0;
  logic ov_a, ov_b;
  logic [2:0] or_a, oc_a, or_b, oc_b;
  logic signed [31:0] oq_a;
  logic signed [23:0] oq_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  coef_prescale u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row(in_row),
    .in_col(in_col), .in_coef(in_coef), .out_valid(ov_a), .out_row(or_a),
    .out_col(oc_a), .out_coef(oq_a));

  coef_prescale #(.IN_W(12), .OUT_W(24), .P1(11), .P2(5)) u_dut24 (.clk(clk),
    .rst_n(rst_n), .in_valid(in_valid), .in_row(in_row), .in_col(in_col),
    .in_coef(in_coef), .out_valid(ov_b), .out_row(or_b), .out_col(oc_b),
    .out_coef(oq_b));

  function automatic real aw(int k);
    real t[8] = '{0.3535533906, 0.4499881115, 0.6532814824, 0.2548977895,
                  0.3535533906, 1.2814577239, 0.2705980501, 0.3006724435};
    return t[k];
  endfunction

  function automatic longint ref_out(int p1, int p2, int r, int c, longint x);
    real s, q;
    longint m, e, y;
    s = aw(r) * aw(c) * real'(longint'(1) << p1);
    m = longint'($floor(s + 0.5));
    q = $floor((s - real'(m)) * real'(longint'(1) << p2) + 0.5);
    e = longint'(q);
    y = x * m + ((x * e) >>> p2);
    if (r == 0 && c == 0) y = y + (longint'(1) << (p1 - 1));
    return y;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(string req, int r, int c, int x);
    @(negedge clk);
    in_valid = 1'b1; in_row = 3'(r); in_col = 3'(c); in_coef = 12'(x);
    @(negedge clk);
    check({req, " valid R2"}, longint'(ov_a & ov_b), 1);
    check({req, " index R3"}, longint'({or_a, oc_a, or_b, oc_b}),
          longint'({3'(r), 3'(c), 3'(r), 3'(c)}));
    check({req, " p18"}, longint'(oq_a), ref_out(18, 3, r, c, x));
    check({req, " p11"}, longint'(oq_b), ref_out(11, 5, r, c, x));
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 out_valid in reset", longint'(ov_a | ov_b), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", longint'(ov_a | ov_b), 0);
  endtask

  task automatic t_dc();
    apply("R8 dc unit", 0, 0, 1);
    check("R8 dc 32768+bias", longint'(oq_a), 163840);
    check("R9 dc 256+bias", longint'(oq_b), 1280);
  endtask

  task automatic t_bias_only_dc();
    apply("R7 dc zero", 0, 0, 0);
    check("R7 dc zero gives bias", longint'(oq_a), 131072);
    apply("R7 off-dc zero", 0, 4, 0);
    check("R7 off-dc zero", longint'(oq_a), 0);
    apply("R7 off-dc zero 24", 7, 0, 0);
    check("R9 off-dc zero", longint'(oq_b), 0);
  endtask

  task automatic t_full_block();
    for (int k = 0; k < 64; k++)
      apply("R4 R5 R6 sweep", k / 8, k % 8, ((k * 37) % 401) - 200);
  endtask

  task automatic t_extremes();
    for (int k = 0; k < 64; k++) begin
      apply("R10 max", k / 8, k % 8, 2047);
      apply("R10 min", k / 8, k % 8, -2047);
    end
    apply("R6 floor neg", 5, 5, -1);
    apply("R6 floor neg", 2, 7, -3);
  endtask

  task automatic t_gap();
    apply("R2 before gap", 3, 3, 5);
    @(negedge clk);
    check("R2 valid drop", longint'(ov_a | ov_b), 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_dc();
    t_bias_only_dc();
    t_full_block();
    t_extremes();
    t_gap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule